// File: doc/BRIEF.md
# Four-Channel Serial Setting Register Interface

This block is a slave on a three-wire serial link. Its inputs are a select line, a data-in line and the link clock. It holds four 8-bit output settings, and each setting has a nonvolatile copy that a neighbouring storage block keeps. While the select line is high, the host sends command frames. A frame is a one start bit, then a two-bit channel number, then eight bits of new data. While the new data arrives, the old value of the addressed channel goes back out on the data-out line. Every read is therefore also a write.

A value written over the link is temporary. It lasts only while select stays high. When select drops, or while reset is held, every output setting shows its nonvolatile copy again. No clock edge is needed for this. Data-out is modelled as a data bit plus an output enable, and the enable follows the select line. There is no valid/ready handshake. The host paces the frames itself and must respect the gap that follows each frame. A start bit is refused while the separate storage controller reports that it is busy.

Top module: `quad_setting_serial`

## Requirements
- R1: A frame is a start bit of 1, then the two address bits, then eight data bits. Fields arrive least significant bit first: A0, A1, then D0 to D7. Each bit is sampled on a rising clock edge while select is high.
- R2: The channel is chosen by {A1,A0}. Value 0 selects the setting in bits 7:0 of `setting`, 1 selects bits 15:8, 2 selects bits 23:16 and 3 selects bits 31:24.
- R3: After the edge that samples A1, `do_bit` shows bit 0 of the addressed channel's current value. After each of the next seven edges it shows the next higher bit.
- R4: The addressed setting keeps its old value through the edge that samples D7. It takes the new data on the following edge.
- R5: A 1 on the data-in line at the two edges after the edge that samples D7 does not start a frame. The earliest accepted start bit is at the third edge.
- R6: `do_oe` equals `cs`. `do_bit` is 0 whenever no readback bit is being shifted out, including while `cs` is low.
- R7: While `cs` is low, every channel of `setting` equals its nonvolatile copy, with no clock edge needed. Any temporary values are discarded.
- R8: Temporary writes to different channels, in any order, all stay in effect while `cs` stays high.
- R9: While `rst_n` is low, `setting` equals `nv_vals` before any clock edge, and `do_oe` follows `cs`.
- R10: If `cs` falls part-way through a frame, that frame updates nothing. The next frame starts cleanly and reads back the nonvolatile value.
- R11: While `prog_busy` is high, a start bit is refused. The frame updates nothing and `do_bit` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock; everything is sampled on its rising edge |
| rst_n | input | 1 | Active-low power-up reset |
| cs | input | 1 | Select: high enables frames and data-out |
| di | input | 1 | Serial data in |
| prog_busy | input | 1 | High while the nonvolatile storage controller is writing |
| nv_vals | input | 32 | Nonvolatile copies, channel 0 in bits 7:0 |
| do_bit | output | 1 | Serial data out value |
| do_oe | output | 1 | Output enable for data out |
| setting | output | 32 | Live output settings, channel 0 in bits 7:0 |

## Verification
The hardest case to reach is a frame cut short by the select line. The stimulus builds up temporary values on several channels. It then drops `cs` in the middle of the data field. When select returns, a full frame to a channel that had been rewritten must read back the nonvolatile value. The post-frame gap gets the same care: the bench drives start-like 1s into exactly the two edges after D7. A design that accepts them would write a spurious value, and the settings would show it.

// File: rtl/qsi_pkg.sv
package qsi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_COMMIT,
    ST_GAP
  } qsi_state_e;
endpackage

// File: rtl/qsi_frame_ctl.sv
module qsi_frame_ctl
  import qsi_pkg::*;
#(
  parameter int AW = 2,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          di,
  input  logic          busy,
  output logic          ld,
  output logic [AW-1:0] ld_addr,
  output logic          shift,
  output logic          wr,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  localparam int CNT_MAX = (DW > AW) ? DW : AW;
  localparam int CW = $clog2(CNT_MAX) + 1;
  localparam logic [CW-1:0] A_LAST = CW'(AW - 1);
  localparam logic [CW-1:0] D_LAST = CW'(DW - 1);

  qsi_state_e    state;
  logic [CW-1:0] cnt;
  logic [AW-1:0] a_sh;
  logic [DW-1:0] d_sh;
  logic [AW:0]   a_cat;
  logic [DW:0]   d_cat;

  always_comb begin
    a_cat = {di, a_sh};
    d_cat = {di, d_sh};
  end

  assign ld      = cs && (state == ST_ADDR) && (cnt == A_LAST);
  assign ld_addr = a_cat[AW:1];
  assign shift   = cs && (state == ST_DATA);
  assign wr      = cs && (state == ST_COMMIT);
  assign wr_addr = a_sh;
  assign wr_data = d_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      a_sh  <= '0;
      d_sh  <= '0;
    end else if (!cs) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (di && !busy) begin
          state <= ST_ADDR;
          cnt   <= '0;
        end
        ST_ADDR: begin
          a_sh <= a_cat[AW:1];
          if (cnt == A_LAST) begin
            state <= ST_DATA;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_DATA: begin
          d_sh <= d_cat[DW:1];
          if (cnt == D_LAST) state <= ST_COMMIT;
          else cnt <= cnt + 1'b1;
        end
        ST_COMMIT: state <= ST_GAP;
        ST_GAP:    state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  // R4
  commit_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> $past(state) == ST_DATA);
  // R5
  gap_follows_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && state == ST_COMMIT) |=> (state == ST_GAP || state == ST_IDLE));
  // R11
  busy_blocks_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && busy) |=> state == ST_IDLE);
endmodule

// File: rtl/qsi_reg_bank.sv
module qsi_reg_bank #(
  parameter int NCH = 4,
  parameter int DW  = 8,
  parameter int AW  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              wr,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [NCH*DW-1:0] nv_flat,
  output logic [NCH*DW-1:0] eff_flat
);
  logic [NCH-1:0] tv;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [DW-1:0] live;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        live  <= '0;
        tv[g] <= 1'b0;
      end else if (!cs) begin
        tv[g] <= 1'b0;
      end else if (wr && wr_addr == AW'(g)) begin
        live  <= wr_data;
        tv[g] <= 1'b1;
      end
    end
    assign eff_flat[g*DW +: DW] = (cs && tv[g]) ? live : nv_flat[g*DW +: DW];
  end

  // R7
  drop_temps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> tv == '0);
  // R8
  temps_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !wr) |=> $stable(tv) || !cs);
endmodule

// File: rtl/qsi_shift_out.sv
module qsi_shift_out #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          ld,
  input  logic          shift,
  input  logic [DW-1:0] ld_val,
  output logic          do_bit
);
  logic [DW-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh <= '0;
    else if (!cs)   sh <= '0;
    else if (ld)    sh <= ld_val;
    else if (shift) sh <= sh >> 1;
  end

  assign do_bit = sh[0];

  // R6
  quiet_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> !do_bit);
  // R3
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !ld && !shift) |=> $stable(do_bit) || !cs);
endmodule

// File: rtl/quad_setting_serial.sv
module quad_setting_serial #(
  parameter int NCH = 4,
  parameter int DW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              di,
  input  logic              prog_busy,
  input  logic [NCH*DW-1:0] nv_vals,
  output logic              do_bit,
  output logic              do_oe,
  output logic [NCH*DW-1:0] setting
);
  localparam int AW = (NCH > 1) ? $clog2(NCH) : 1;

  logic          ld, shift, wr;
  logic [AW-1:0] ld_addr, wr_addr;
  logic [DW-1:0] wr_data;
  logic [DW-1:0] eff_arr [NCH];

  qsi_frame_ctl #(.AW(AW), .DW(DW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .cs(cs), .di(di), .busy(prog_busy),
    .ld(ld), .ld_addr(ld_addr), .shift(shift),
    .wr(wr), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  qsi_reg_bank #(.NCH(NCH), .DW(DW), .AW(AW)) u_bank (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .wr_addr(wr_addr),
    .wr_data(wr_data), .nv_flat(nv_vals), .eff_flat(setting)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_unpack
    assign eff_arr[g] = setting[g*DW +: DW];
  end

  qsi_shift_out #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .cs(cs), .ld(ld), .shift(shift),
    .ld_val(eff_arr[ld_addr]), .do_bit(do_bit)
  );

  assign do_oe = cs;
endmodule

// File: tb/tb_quad_setting_serial.sv
module tb_quad_setting_serial;
  localparam int PER = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs = 1'b0;
  logic        di = 1'b0;
  logic        prog_busy = 1'b0;
  logic [31:0] nv_vals = 32'hD4C3B2A1;
  logic        do_bit, do_oe;
  logic [31:0] setting;

  int total = 0;
  int bad = 0;
  logic [7:0] mdl [4];

  quad_setting_serial dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .di(di), .prog_busy(prog_busy),
    .nv_vals(nv_vals), .do_bit(do_bit), .do_oe(do_oe), .setting(setting)
  );

  always #(PER/2) clk = ~clk;

  // {addr[17:16], new data[15:8], expected readback[7:0]}
  localparam logic [17:0] VEC [6] = '{
    {2'd0, 8'h11, 8'hA1},
    {2'd2, 8'h33, 8'hC3},
    {2'd0, 8'h55, 8'h11},
    {2'd3, 8'h77, 8'hD4},
    {2'd1, 8'h99, 8'hB2},
    {2'd2, 8'hEE, 8'h33}
  };

  function automatic logic [31:0] packed_mdl();
    return {mdl[3], mdl[2], mdl[1], mdl[0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input logic d);
    @(negedge clk);
    di = d;
    @(posedge clk);
    #1;
  endtask

  task automatic reload_mdl();
    for (int i = 0; i < 4; i++) mdl[i] = nv_vals[i*8 +: 8];
  endtask

  // full frame; gapv is driven on the two edges after D7
  task automatic frame(input logic [1:0] a, input logic [7:0] d, input logic gapv,
                       output logic [7:0] rb);
    tick(1'b1);
    tick(a[0]);
    tick(a[1]);
    rb[0] = do_bit;
    for (int i = 0; i < 8; i++) begin
      tick(d[i]);
      if (i < 7) rb[i+1] = do_bit;
    end
    check("R4 held through D7 edge", setting, packed_mdl());
    tick(gapv);
    mdl[a] = d;
    check("R1 R2 update after D7", setting, packed_mdl());
    tick(gapv);
  endtask

  initial begin
    #(PER * 100000);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] rb;
    reload_mdl();
    #1;
    check("R9 setting at power-up", setting, nv_vals);
    check("R9 do_oe low", {31'd0, do_oe}, 32'd0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cs = 1'b1;
    #1;
    check("R6 do_oe follows cs", {31'd0, do_oe}, 32'd1);
    check("R6 do_bit idle low", {31'd0, do_bit}, 32'd0);

    for (int v = 0; v < 6; v++) begin
      frame(VEC[v][17:16], VEC[v][15:8], 1'b0, rb);
      check("R3 readback", {24'd0, rb}, {24'd0, VEC[v][7:0]});
    end
    check("R8 temporaries held", setting, {8'h77, 8'hEE, 8'h99, 8'h55});

    // gap edges carry 1s: must not start a frame
    frame(2'd1, 8'h42, 1'b1, rb);
    check("R3 readback before gap test", {24'd0, rb}, 32'h99);
    for (int i = 0; i < 12; i++) begin
      tick(1'b0);
      if (do_bit !== 1'b0) check("R5 no output after gap 1s", {31'd0, do_bit}, 32'd0);
    end
    check("R5 gap 1s ignored", setting, packed_mdl());

    // deselect reloads all channels
    @(negedge clk);
    cs = 1'b0;
    #1;
    check("R7 reload on cs low", setting, nv_vals);
    check("R6 do_oe low", {31'd0, do_oe}, 32'd0);
    nv_vals = 32'h0F1E2D3C;
    #1;
    check("R7 follows copies", setting, 32'h0F1E2D3C);
    reload_mdl();
    tick(1'b0);
    @(negedge clk);
    cs = 1'b1;
    #1;
    check("R7 temps discarded", setting, nv_vals);

    // abort mid-frame
    frame(2'd2, 8'hA5, 1'b0, rb);
    tick(1'b1);
    tick(1'b0);
    tick(1'b1);
    for (int i = 0; i < 4; i++) tick(1'b1);
    @(negedge clk);
    cs = 1'b0;
    tick(1'b0);
    @(negedge clk);
    cs = 1'b1;
    reload_mdl();
    #1;
    check("R10 abort leaves copies", setting, nv_vals);
    frame(2'd2, 8'h66, 1'b0, rb);
    check("R10 clean restart readback", {24'd0, rb}, {24'd0, nv_vals[23:16]});

    // busy storage controller
    @(negedge clk);
    prog_busy = 1'b1;
    begin
      logic seen;
      seen = 1'b0;
      tick(1'b1);
      tick(1'b1);
      tick(1'b1);
      for (int i = 0; i < 10; i++) begin
        tick(1'b1);
        seen |= do_bit;
      end
      check("R11 do_bit low while busy", {31'd0, seen}, 32'd0);
    end
    check("R11 no update while busy", setting, packed_mdl());
    @(negedge clk);
    prog_busy = 1'b0;
    di = 1'b0;
    tick(1'b0);
    tick(1'b0);
    frame(2'd3, 8'h81, 1'b0, rb);
    check("R2 channel 3 readback", {24'd0, rb}, {24'd0, nv_vals[31:24]});

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule